// File: doc/BRIEF.md
# Single-Wire Debug Serial Port

This block is the target end of a single-wire serial debug link in which the host sets the pace. The line is shared and pulled high. The host pulls it low to start every bit, whichever way the bit travels. The block synchronizes the line into the system clock domain and treats each detected falling edge as the start of a new bit time. A bit from the host is read at a fixed offset after that edge. A bit going to the host is returned by pulling the line low for a fixed window, and only when the bit is a 0.

Bits arrive most significant first. Each group of eight becomes a byte on a parallel output, marked by a one-cycle valid pulse. The first byte of a transfer is also kept in a command register. It stays there until the command decoder clears it or the link times out. A byte for the host is handed in through a valid/ready handshake and is sent on the next eight host edges. If a byte is only partly moved in either direction and the host then stops sending edges, a watchdog aborts it and clears the command register.

Top module: `dbg_line_port`

## Requirements
- R1: Bits from the host are shifted in most significant bit first. After the eighth bit, `rx_data_o` holds the byte and `rx_valid_o` is high for exactly one cycle. The next bit then starts a new byte.
- R2: The block perceives a host falling edge two register stages after the line change. A bit is read from the line level eleven cycles after the host pulls the line low (at phase 10 after the perceived edge). A low of 10 cycles reads as 1 and a low of 11 cycles reads as 0.
- R3: The first byte received after reset, after a timeout or after a `cmd_clr_i` pulse is loaded into `cmd_o` and sets `cmd_valid_o`. Later bytes do not change it. `cmd_clr_i` clears `cmd_valid_o` on the next edge.
- R4: A byte is accepted when `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` is low from the next cycle until the eighth host edge after that has been processed.
- R5: A byte being sent goes out most significant bit first, one bit per host edge. For a 0 bit, `line_drive_o` is high from the perceived edge (phase 0) through phase 12, which is 13 cycles, and then low. For a 1 bit it stays low.
- R6: While the block is receiving a bit from the host, `line_drive_o` stays low. Bits sent to the host never appear as received bytes.
- R7: When a byte is partly moved and no host falling edge is perceived for 512 cycles, `timeout_o` pulses for one cycle. The pulse comes 515 cycles after the host pulled the line low. The partial byte is dropped, `cmd_o` and `cmd_valid_o` are cleared, a send in progress is abandoned (`tx_ready_o` goes high again), and the next bit starts a fresh byte.
- R8: A gap between host edges of fewer than 512 cycles does not abort the partial byte.
- R9: When no byte is partly moved, an idle line never raises `timeout_o`.
- R10: After reset, `line_drive_o`, `rx_valid_o`, `cmd_valid_o` and `timeout_o` are low and `tx_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Level of the shared debug line (asynchronous) |
| line_drive_o | output | 1 | Pull the line low when high (open-drain enable) |
| tx_valid_i | input | 1 | Byte to send is offered |
| tx_data_i | input | DATA_W | Byte to send |
| tx_ready_o | output | 1 | Sender can accept a byte |
| rx_valid_o | output | 1 | One-cycle pulse: received byte available |
| rx_data_o | output | DATA_W | Last received byte |
| cmd_valid_o | output | 1 | Command register holds a byte |
| cmd_o | output | DATA_W | Command register |
| cmd_clr_i | input | 1 | Release the command register |
| timeout_o | output | 1 | One-cycle pulse: partial transfer aborted |

## Verification
Host bytes are sent with ordinary bit shapes (short low for 1, long low for 0) and with shapes that sit one cycle on each side of the sampling point. Together these separate the correct sample phase from one that is off by one. Target bytes with mixed bits are read back while every cycle of `line_drive_o` is compared with the expected 13-cycle window. This catches windows that are shifted or too long, drive during received bits, and wrong bit order. Gaps of 500 cycles, idle spans of 700 cycles and silent spans after partial receives and partial sends separate a correct watchdog from one that fires too early, one that fires on an idle line, and one that leaves stale bits or a stale command behind.

// File: rtl/dbg_line_pkg.sv
package dbg_line_pkg;
  localparam int unsigned DEF_DATA_W      = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_SAMPLE_AT   = 10;
  localparam int unsigned DEF_DRIVE_END   = 12;
  localparam int unsigned DEF_TIMEOUT     = 512;

  typedef struct packed {
    logic sample;   // read point of a host bit
    logic win;      // drive window of a target 0 bit, edge cycle excluded
    logic expired;  // watchdog fired on a partial transfer
  } bit_evt_t;
endpackage

// File: rtl/dbg_edge_sync.sv
module dbg_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  // chain_q[0] is the newest sample; the last stage is the previous level
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], line_i};
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/dbg_bit_timer.sv
module dbg_bit_timer
  import dbg_line_pkg::*;
#(
  parameter int unsigned SAMPLE_AT = DEF_SAMPLE_AT,
  parameter int unsigned DRIVE_END = DEF_DRIVE_END,
  parameter int unsigned TIMEOUT   = DEF_TIMEOUT
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     fall_i,
  input  logic     active_i,
  output bit_evt_t evt_o
);
  localparam int unsigned PH_W = $clog2(DRIVE_END + 2);
  localparam int unsigned TO_W = $clog2(TIMEOUT + 1);
  localparam logic [PH_W-1:0] PH_IDLE   = PH_W'(DRIVE_END + 1);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SAMPLE_AT);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(DRIVE_END);
  localparam logic [TO_W-1:0] TO_LIM    = TO_W'(TIMEOUT);

  logic [PH_W-1:0] ph_q;
  logic [TO_W-1:0] to_q;
  logic            expired;

  // phase counts cycles since the perceived edge and parks past the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ph_q <= PH_IDLE;
    else if (fall_i)           ph_q <= PH_W'(1);
    else if (ph_q != PH_IDLE)  ph_q <= ph_q + PH_W'(1);
  end

  // cycles since the last edge, saturating; 0 means no edge seen yet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                to_q <= '0;
    else if (fall_i)                            to_q <= TO_W'(1);
    else if (expired)                           to_q <= '0;
    else if (to_q != '0 && to_q != TO_LIM)      to_q <= to_q + TO_W'(1);
  end

  assign expired       = active_i & ~fall_i & (to_q == TO_LIM);
  assign evt_o.sample  = ~fall_i & (ph_q == PH_SAMPLE);
  assign evt_o.win     = ~fall_i & (ph_q <= PH_LAST);
  assign evt_o.expired = expired;
endmodule

// File: rtl/dbg_rx_path.sv
module dbg_rx_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              level_i,
  input  logic              sample_i,
  input  logic              tx_owns_i,
  input  logic              abort_i,
  input  logic              cmd_clr_i,
  output logic              listen_o,
  output logic              partial_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic              listen_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_nx;

  assign sh_nx = {sh_q[DATA_W-2:0], level_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      listen_q    <= 1'b0;
      cnt_q       <= '0;
      sh_q        <= '0;
      valid_o     <= 1'b0;
      data_o      <= '0;
      cmd_valid_o <= 1'b0;
      cmd_o       <= '0;
    end else begin
      valid_o <= 1'b0;
      if (abort_i) begin
        listen_q    <= 1'b0;
        cnt_q       <= '0;
        sh_q        <= '0;
        cmd_valid_o <= 1'b0;
        cmd_o       <= '0;
      end else begin
        if (cmd_clr_i) cmd_valid_o <= 1'b0;
        if (fall_i) begin
          listen_q <= ~tx_owns_i;
        end else if (sample_i && listen_q) begin
          listen_q <= 1'b0;
          if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            data_o  <= sh_nx;
            valid_o <= 1'b1;
            if (!cmd_valid_o) begin
              cmd_o       <= sh_nx;
              cmd_valid_o <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            sh_q  <= sh_nx;
          end
        end
      end
    end
  end

  assign listen_o  = listen_q;
  assign partial_o = (cnt_q != '0);
endmodule

// File: rtl/dbg_tx_path.sv
module dbg_tx_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              win_i,
  input  logic              abort_i,
  input  logic              load_valid_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              partial_o,
  output logic              drive_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic              busy_q;
  logic              zero_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      zero_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      if (abort_i) begin
        busy_q <= 1'b0;
        zero_q <= 1'b0;
        cnt_q  <= '0;
      end else if (fall_i) begin
        zero_q <= busy_q & ~sh_q[DATA_W-1];
        if (busy_q) begin
          sh_q <= {sh_q[DATA_W-2:0], 1'b0};
          if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
      // never coincides with a busy shift, so it may follow the branch above
      if (load_valid_i && !busy_q) begin
        sh_q   <= load_data_i;
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  // the edge cycle itself already pulls low for a 0 bit
  assign drive_o   = fall_i ? (busy_q & ~sh_q[DATA_W-1]) : (zero_q & win_i);
  assign ready_o   = ~busy_q;
  assign busy_o    = busy_q;
  assign partial_o = (cnt_q != '0);
endmodule

// File: rtl/dbg_line_port.sv
module dbg_line_port
  import dbg_line_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned SAMPLE_AT   = DEF_SAMPLE_AT,
  parameter int unsigned DRIVE_END   = DEF_DRIVE_END,
  parameter int unsigned TIMEOUT     = DEF_TIMEOUT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              line_drive_o,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_o,
  input  logic              cmd_clr_i,
  output logic              timeout_o
);
  logic     level;
  logic     fall;
  logic     rx_listen;
  logic     rx_partial;
  logic     tx_busy;
  logic     tx_partial;
  logic     timeout_q;
  bit_evt_t evt;

  dbg_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .level_o(level),
    .fall_o (fall)
  );

  dbg_bit_timer #(
    .SAMPLE_AT(SAMPLE_AT),
    .DRIVE_END(DRIVE_END),
    .TIMEOUT  (TIMEOUT)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (fall),
    .active_i(rx_partial | tx_partial),
    .evt_o   (evt)
  );

  dbg_rx_path #(.DATA_W(DATA_W)) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall),
    .level_i    (level),
    .sample_i   (evt.sample),
    .tx_owns_i  (tx_busy),
    .abort_i    (evt.expired),
    .cmd_clr_i  (cmd_clr_i),
    .listen_o   (rx_listen),
    .partial_o  (rx_partial),
    .valid_o    (rx_valid_o),
    .data_o     (rx_data_o),
    .cmd_valid_o(cmd_valid_o),
    .cmd_o      (cmd_o)
  );

  dbg_tx_path #(.DATA_W(DATA_W)) i_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fall_i      (fall),
    .win_i       (evt.win),
    .abort_i     (evt.expired),
    .load_valid_i(tx_valid_i),
    .load_data_i (tx_data_i),
    .ready_o     (tx_ready_o),
    .busy_o      (tx_busy),
    .partial_o   (tx_partial),
    .drive_o     (line_drive_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timeout_q <= 1'b0;
    else         timeout_q <= evt.expired;
  end

  assign timeout_o = timeout_q;
endmodule

// File: rtl/dbg_line_port_chk.sv
module dbg_line_port_chk #(
  parameter int unsigned DRIVE_END = 12
) (
  input logic clk_i,
  input logic rst_ni,
  input logic drive_i,
  input logic fall_i,
  input logic listen_i,
  input logic tx_valid_i,
  input logic tx_ready_i,
  input logic rx_valid_i,
  input logic timeout_i,
  input logic cmd_valid_i
);
  localparam int unsigned RUN_W = $clog2(DRIVE_END + 2);

  // consecutive drive cycles before the current one
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   run_q <= '0;
    else if (!drive_i)             run_q <= '0;
    else if (run_q != '1)          run_q <= run_q + RUN_W'(1);
  end

  assert_rx_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i);

  assert_load_takes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_i |=> !tx_ready_i);

  assert_drive_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_i |-> run_q <= RUN_W'(DRIVE_END));

  assert_quiet_rx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    listen_i && !fall_i |-> !drive_i);

  assert_to_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |-> !cmd_valid_i);

  assert_to_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> !timeout_i);
endmodule

bind dbg_line_port dbg_line_port_chk #(.DRIVE_END(DRIVE_END)) i_dbg_line_port_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .drive_i    (line_drive_o),
  .fall_i     (fall),
  .listen_i   (rx_listen),
  .tx_valid_i (tx_valid_i),
  .tx_ready_i (tx_ready_o),
  .rx_valid_i (rx_valid_o),
  .timeout_i  (timeout_o),
  .cmd_valid_i(cmd_valid_o)
);

// File: tb/test_dbg_line_port.sv
`timescale 1ns/1ps
module test_dbg_line_port;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_low = 1'b0;
  logic       tx_valid_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       cmd_clr_i = 1'b0;
  logic       line_i;
  logic       line_drive_o;
  logic       tx_ready_o;
  logic       rx_valid_o;
  logic [7:0] rx_data_o;
  logic       cmd_valid_o;
  logic [7:0] cmd_o;
  logic       timeout_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int last_p = 0;
  int drv_err = 0;
  logic [7:0] rx_q[$];
  int to_log[$];
  bit exp_drv[int];

  always #2.5 clk = ~clk;

  // wired-AND line: host or target may pull low
  assign line_i = ~(host_low | line_drive_o);

  dbg_line_port i_dbg_line_port (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line_i), .line_drive_o(line_drive_o),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .tx_ready_o(tx_ready_o),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .cmd_valid_o(cmd_valid_o),
    .cmd_o(cmd_o), .cmd_clr_i(cmd_clr_i), .timeout_o(timeout_o));

  always @(posedge clk) cyc <= cyc + 1;

  // reference: drive expected exactly in the windows the bench scheduled
  always @(negedge clk) begin
    if (rst_ni) begin
      if (rx_valid_o) rx_q.push_back(rx_data_o);
      if (timeout_o) to_log.push_back(cyc);
      if (line_drive_o !== exp_drv.exists(cyc)) begin
        drv_err++;
        fails++;
        $display("FAIL R5,R6 drive at cycle %0d: actual %0d expected %0d",
                 cyc, line_drive_o, exp_drv.exists(cyc));
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // host pulls low for low_n cycles of a 16-cycle bit
  task automatic host_pulse(int low_n);
    last_p = cyc;
    host_low = 1'b1;
    repeat (low_n) tick();
    host_low = 1'b0;
    repeat (16 - low_n) tick();
  endtask

  task automatic send_byte(logic [7:0] b, int one_low, int zero_low);
    for (int i = 7; i >= 0; i--) host_pulse(b[i] ? one_low : zero_low);
  endtask

  // host starts a bit, releases, reads the line 10 cycles after pulling low
  task automatic read_bit(bit exp_zero, output bit val);
    last_p = cyc;
    if (exp_zero) for (int c = cyc + 2; c <= cyc + 14; c++) exp_drv[c] = 1'b1;
    host_low = 1'b1;
    repeat (2) tick();
    host_low = 1'b0;
    repeat (8) tick();
    val = line_i;
    repeat (6) tick();
  endtask

  task automatic read_byte(logic [7:0] exp, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      bit v;
      read_bit(~exp[i], v);
      got[i] = v;
      if (i == 4) check(tx_ready_o == 1'b0, "R4", "ready mid shift", tx_ready_o, 0);
    end
  endtask

  task automatic load(logic [7:0] d);
    check(tx_ready_o == 1'b1, "R4", "ready before load", tx_ready_o, 1);
    tx_valid_i = 1'b1;
    tx_data_i  = d;
    tick();
    tx_valid_i = 1'b0;
    check(tx_ready_o == 1'b0, "R4", "ready after load", tx_ready_o, 0);
  endtask

  task automatic expect_rx(logic [7:0] e, string req);
    check(rx_q.size() == 1, req, "byte count", rx_q.size(), 1);
    if (rx_q.size() > 0) begin
      logic [7:0] g;
      g = rx_q.pop_front();
      check(g == e, req, "byte value", g, e);
    end
    rx_q.delete();
  endtask

  task automatic clear_cmd();
    cmd_clr_i = 1'b1;
    tick();
    cmd_clr_i = 1'b0;
    check(cmd_valid_o == 1'b0, "R3", "cmd_valid after clear", cmd_valid_o, 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] got;
    bit b;
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (3) tick();

    // R10 reset state
    check(line_drive_o == 1'b0 && rx_valid_o == 1'b0, "R10", "drive/valid", {line_drive_o, rx_valid_o}, 0);
    check(tx_ready_o == 1'b1, "R10", "ready", tx_ready_o, 1);
    check(cmd_valid_o == 1'b0 && timeout_o == 1'b0, "R10", "cmd_valid/timeout", {cmd_valid_o, timeout_o}, 0);

    // R1, R3 first byte becomes command
    send_byte(8'hA5, 4, 13);
    expect_rx(8'hA5, "R1");
    check(cmd_valid_o && cmd_o == 8'hA5, "R3", "cmd first byte", cmd_o, 8'hA5);
    send_byte(8'h3C, 4, 13);
    expect_rx(8'h3C, "R1");
    check(cmd_valid_o && cmd_o == 8'hA5, "R3", "cmd held", cmd_o, 8'hA5);
    clear_cmd();
    send_byte(8'h81, 4, 13);
    expect_rx(8'h81, "R1");
    check(cmd_valid_o && cmd_o == 8'h81, "R3", "cmd after clear", cmd_o, 8'h81);

    // R2 one cycle each side of the read point
    send_byte(8'h5A, 10, 11);
    expect_rx(8'h5A, "R2");
    send_byte(8'hC6, 10, 11);
    expect_rx(8'hC6, "R2");

    // R4, R5, R6 sending to host
    load(8'hC3);
    read_byte(8'hC3, got);
    check(got == 8'hC3, "R5", "sent byte", got, 8'hC3);
    check(tx_ready_o == 1'b1, "R4", "ready after 8 edges", tx_ready_o, 1);
    check(rx_q.size() == 0, "R6", "no rx from sent bits", rx_q.size(), 0);
    load(8'h0F);
    read_byte(8'h0F, got);
    check(got == 8'h0F, "R5", "sent byte", got, 8'h0F);

    // R7 partial receive then silence
    clear_cmd();
    send_byte(8'h77, 4, 13);
    expect_rx(8'h77, "R3");
    check(cmd_valid_o == 1'b1, "R3", "cmd set", cmd_valid_o, 1);
    host_pulse(4); host_pulse(13); host_pulse(4);
    repeat (530) tick();
    check(to_log.size() == 1, "R7", "timeout count", to_log.size(), 1);
    if (to_log.size() > 0) check(to_log[0] == last_p + 515, "R7", "timeout cycle", to_log[0], last_p + 515);
    check(cmd_valid_o == 1'b0 && cmd_o == 8'h00, "R7", "cmd cleared", cmd_o, 0);
    check(rx_q.size() == 0, "R7", "partial dropped", rx_q.size(), 0);
    send_byte(8'h96, 4, 13);
    expect_rx(8'h96, "R7");
    check(cmd_valid_o && cmd_o == 8'h96, "R3", "cmd after timeout", cmd_o, 8'h96);

    // R8 long but legal gap
    host_pulse(4); host_pulse(4); host_pulse(4);
    repeat (484) tick();
    host_pulse(13); host_pulse(13); host_pulse(13); host_pulse(13); host_pulse(4);
    expect_rx(8'hE1, "R8");
    check(to_log.size() == 1, "R8", "no timeout on 500 gap", to_log.size(), 1);

    // R9 idle line
    repeat (700) tick();
    check(to_log.size() == 1, "R9", "no idle timeout", to_log.size(), 1);

    // R7 partial send then silence
    load(8'h55);
    read_bit(1'b1, b);
    check(b == 1'b0, "R5", "first sent bit", b, 0);
    read_bit(1'b0, b);
    check(b == 1'b1, "R5", "second sent bit", b, 1);
    repeat (530) tick();
    check(to_log.size() == 2, "R7", "tx timeout count", to_log.size(), 2);
    if (to_log.size() > 1) check(to_log[1] == last_p + 515, "R7", "tx timeout cycle", to_log[1], last_p + 515);
    check(tx_ready_o == 1'b1, "R7", "send abandoned", tx_ready_o, 1);

    check(drv_err == 0, "R5,R6", "per-cycle drive mismatches", drv_err, 0);
    summary();
    $finish;
  end
endmodule